// File: doc/BRIEF.md
# Two-level grouped carry-lookahead adder

This block is a purely combinational unsigned adder. It takes two operands of a parameterised width (32 bits by default) and a carry-in, and returns the sum together with the carry-out. It has no registers and no clock.

The operand bits are split into 4-bit lookahead cells. Each cell forms its four internal carries as flat sum-of-products terms built from bit generate (a AND b) and bit propagate (a OR b). Each cell also exports a group generate and a group propagate. A second lookahead unit turns those group terms and the carry-in into the carry entering every cell, again as flat products. As a result, no carry travels bit by bit along the operand.

The adder suits address paths, accumulators and multiplier final stages, where the sum must settle in a bounded logic depth.

Top module: `cla2_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of the arithmetic value a + b + cin for every input combination.
- R2: `cout` equals bit WIDTH (the bit just above the most significant sum bit) of a + b + cin.
- R3: All ones on `a`, zero on `b` and `cin` = 1 give `sum` = 0 and `cout` = 1.
- R4: Zero plus zero gives `sum` = 0 and `cout` = 0 when `cin` = 0, and `sum` = 1 and `cout` = 0 when `cin` = 1.
- R5: When `b` is the bitwise complement of `a`, so that every bit propagates, `cin` = 1 yields `sum` = 0 and `cout` = 1, and `cin` = 0 yields all ones and `cout` = 0.
- R6: The carry leaving each 4-bit cell equals that cell's group generate OR (group propagate AND the cell's carry-in). A carry born in one cell reaches every higher cell through this relation.
- R7: WIDTH may be any positive multiple of 4 (default 32). Any other value stops elaboration. A 12-bit build obeys R1 and R2.
- R8: A carry generated in the top bit alone (only the most significant bit set in both operands, `cin` = 0) gives `sum` = 0 and `cout` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant cell |

## Verification
Random operand pairs with a random carry-in exercise general generate and kill mixes, and catch wrong product terms in both lookahead levels. Complement pairs (b = ~a) make every bit propagate, so only the chained group-propagate products can deliver the carry-in to the top. Without those products these vectors fail where random ones rarely do. Nibble patterns such as 0x0000000F + 1 and 0x0FFFFFFF + 1 place a generate just below a cell boundary, which isolates the second-level carry for a single cell. The all-ones, zero and top-bit-only cases pin the carry-out and the carry-in path at both ends of the word.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // Width of one first-level lookahead cell.
   localparam int unsigned CELL_W = 4;

   // Number of first-level cells for a given operand width.
   function automatic int unsigned cell_count(input int unsigned width);
      return width / CELL_W;
   endfunction
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] gen,
   output logic [W-1:0] prop,
   output logic [W-1:0] half
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign gen[i]  = a[i] & b[i];
      assign prop[i] = a[i] | b[i];
      assign half[i] = a[i] ^ b[i];
   end
endmodule

// File: rtl/cla_cell4.sv
module cla_cell4 (
   input  logic [3:0] gen,
   input  logic [3:0] prop,
   input  logic [3:0] half,
   input  logic       c_in,
   output logic [3:0] sum,
   output logic       grp_gen,
   output logic       grp_prop,
   output logic       c_out
);
   logic [3:0] c;

   // Flat sum-of-products carries: no term waits on another carry.
   assign c[0] = c_in;
   assign c[1] = gen[0] | (prop[0] & c_in);
   assign c[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & c_in);
   assign c[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
               | (prop[2] & prop[1] & prop[0] & c_in);
   assign c_out = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
                | (prop[3] & prop[2] & prop[1] & gen[0])
                | (prop[3] & prop[2] & prop[1] & prop[0] & c_in);

   assign sum = half ^ c;

   assign grp_gen  = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
                   | (prop[3] & prop[2] & prop[1] & gen[0]);
   assign grp_prop = &prop;

   logic [4:0] cell_ref;
   always_comb begin
      cell_ref = {1'b0, half} + {gen, 1'b0} + {4'b0000, c_in};
      // R6
      cell_exit_chk: assert (c_out == (grp_gen | (grp_prop & c_in)))
         else $error("cell carry-out disagrees with group generate/propagate");
      // R1
      cell_sum_chk: assert ({c_out, sum} == cell_ref)
         else $error("cell result differs from arithmetic sum of its bits");
   end
endmodule

// File: rtl/cla_group_carry.sv
module cla_group_carry #(
   parameter int unsigned NG = 8
) (
   input  logic [NG-1:0] grp_gen,
   input  logic [NG-1:0] grp_prop,
   input  logic          c_in,
   output logic [NG:0]   c_grp
);
   // Second lookahead level: each group carry-in is a flat OR of
   // products over the lower groups' generate/propagate terms.
   always_comb begin
      c_grp    = '0;
      c_grp[0] = c_in;
      for (int k = 1; k <= NG; k++) begin
         automatic logic term = 1'b0;
         automatic logic span = 1'b1;
         for (int j = k - 1; j >= 0; j--) begin
            term = term | (grp_gen[j] & span);
            span = span & grp_prop[j];
         end
         c_grp[k] = term | (c_in & span);
      end
   end

   always_comb begin
      for (int k = 0; k < NG; k++) begin
         // R6
         grp_chain_chk: assert (c_grp[k+1] == (grp_gen[k] | (grp_prop[k] & c_grp[k])))
            else $error("group carry %0d breaks the generate/propagate chain", k + 1);
      end
   end
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder
   import cla_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int unsigned NG = cell_count(WIDTH);

   // R7
   if (WIDTH == 0 || (WIDTH % CELL_W) != 0) begin : g_width_bad
      $error("cla2_adder: WIDTH must be a positive multiple of %0d", CELL_W);
   end

   logic [WIDTH-1:0] gen, prop, half;
   logic [NG-1:0]    grp_gen, grp_prop, cell_co;
   logic [NG:0]      c_grp;

   cla_bit_pg #(.W(WIDTH)) u_pg (
      .a    (a),
      .b    (b),
      .gen  (gen),
      .prop (prop),
      .half (half)
   );

   cla_group_carry #(.NG(NG)) u_lvl2 (
      .grp_gen  (grp_gen),
      .grp_prop (grp_prop),
      .c_in     (cin),
      .c_grp    (c_grp)
   );

   for (genvar i = 0; i < NG; i++) begin : g_cell
      cla_cell4 u_cell (
         .gen      (gen[i*CELL_W +: CELL_W]),
         .prop     (prop[i*CELL_W +: CELL_W]),
         .half     (half[i*CELL_W +: CELL_W]),
         .c_in     (c_grp[i]),
         .sum      (sum[i*CELL_W +: CELL_W]),
         .grp_gen  (grp_gen[i]),
         .grp_prop (grp_prop[i]),
         .c_out    (cell_co[i])
      );
   end

   assign cout = c_grp[NG];

   logic [WIDTH:0] add_ref;
   always_comb begin
      add_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      // R1 R2
      add_result_chk: assert ({cout, sum} == add_ref)
         else $error("adder result differs from a+b+cin");
      // R6
      top_exit_chk: assert (cout == cell_co[NG-1])
         else $error("second-level carry-out disagrees with top cell");
   end
endmodule

// File: tb/cla2_adder_tb.sv
module cla2_adder_tb;
   localparam int W  = 32;
   localparam int W2 = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [W-1:0]  a, b, sum;
   logic          cin, cout;
   logic [W2-1:0] sum12;
   logic          cout12;

   cla2_adder #(.WIDTH(W)) u_dut (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
   );
   // R7: a non-default multiple of 4
   cla2_adder #(.WIDTH(W2)) u_dut12 (
      .a(a[W2-1:0]), .b(b[W2-1:0]), .cin(cin), .sum(sum12), .cout(cout12)
   );

   logic [W:0]  exp_q[$];
   logic [W2:0] exp12_q[$];
   string       tag_q[$];
   int applied = 0;
   int errors  = 0;
   bit done    = 1'b0;

   task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                        input logic vc, input string tag);
      @(posedge clk);
      a   <= va;
      b   <= vb;
      cin <= vc;
      exp_q.push_back({1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc});
      exp12_q.push_back({1'b0, va[W2-1:0]} + {1'b0, vb[W2-1:0]} + {{W2{1'b0}}, vc});
      tag_q.push_back(tag);
   endtask

   // Monitor: results settle well before the falling edge.
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         logic [W:0]  e;
         logic [W2:0] e12;
         string       t;
         e   = exp_q.pop_front();
         e12 = exp12_q.pop_front();
         t   = tag_q.pop_front();
         applied++;
         if ({cout, sum} !== e) begin
            errors++;
            $display("FAIL %s: {cout,sum}=%h expected %h", t, {cout, sum}, e);
         end
         applied++;
         if ({cout12, sum12} !== e12) begin
            errors++;
            $display("FAIL R7 (12-bit, %s): {cout,sum}=%h expected %h", t, {cout12, sum12}, e12);
         end
      end
   end

   initial begin
      a = '0; b = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst_n <= 1'b1;
      // R4 reset-state inputs: zero plus zero
      drive('0, '0, 1'b0, "R4 zero+zero");
      drive('0, '0, 1'b1, "R4 zero+zero+cin");
      // R3
      drive('1, '0, 1'b1, "R3 ones+cin");
      drive('1, 32'd1, 1'b0, "R3 ones+one");
      // R5 full-width propagation
      drive(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1, "R5 propagate cin1");
      drive(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b0, "R5 propagate cin0");
      drive(32'h0000_0000, 32'hFFFF_FFFF, 1'b1, "R5 propagate zero/ones");
      // R8
      drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R8 top generate");
      // R6 carries generated just under a cell boundary
      drive(32'h0000_000F, 32'd1, 1'b0, "R6 nibble boundary");
      drive(32'h0FFF_FFFF, 32'd1, 1'b0, "R6 seven cells");
      drive(32'h00FF_0F00, 32'h0001_0100, 1'b0, "R6 mixed cells");
      drive(32'hFFFF_FFF0, 32'h0000_0010, 1'b0, "R6 generate in cell 1");
      // R1 R2 random
      for (int i = 0; i < 300; i++)
         drive($urandom, $urandom, 1'($urandom), "R1/R2 random");
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, got %0d applied expected completion", applied);
         $display("  == %0d vectors applied, %0d miscompares ==", applied, errors);
         $finish;
      end
   end
endmodule